// File: doc/BRIEF.md
# USB IN Endpoint Packet Buffer

This block controls the transmit buffer of one configurable USB device IN endpoint. A CPU-side port writes packet bytes into a shared FIFO memory. A packet is committed in one of two ways. A manual ready strobe commits it. With auto-commit enabled, the packet commits by itself once its byte count reaches the programmed maximum packet size. The memory holds committed packets, not loose words. Each slot keeps its byte count next to it, so the USB side sends exactly what was committed, including zero-length packets.

With double buffering requested and the memory deep enough, the memory splits into two halves. Loads and sends then alternate between the halves in a ping-pong scheme. Otherwise one packet at a time is held, using the whole memory. The CPU watches a ready flag and a not-empty flag. It is told through a one-cycle endpoint interrupt when it may load again. The USB side reads the head packet byte by byte and pulses a success strobe when the packet has gone. A synchronous flush discards everything.

Top module: `usb_in_pktbuf`

## Requirements
- R1: After reset, `txrdy`, `fifo_ne`, `ep_irq`, `overrun` and `usb_pkt_valid` are all 0.
- R2: Double buffering takes effect only when 2*`cfg_maxp` <= DEPTH. Otherwise the block holds one packet even with `cfg_dbl`=1, and `txrdy` goes to 1 as soon as that packet commits.
- R3: In single mode, `txrdy` and `fifo_ne` go to 1 on the cycle after a commit. They stay 1 until the packet is reported sent. Bytes written meanwhile are dropped.
- R4: With `cfg_auto`=1, the write that brings the loaded count to `cfg_maxp` commits the packet with no strobe. In single mode, `txrdy` is 1 on the following cycle.
- R5: A packet shorter than `cfg_maxp` commits only on `cpu_set_rdy`, whatever `cfg_auto` is. Until then, `txrdy` and `fifo_ne` stay 0.
- R6: Pulsing `usb_sent` while `usb_pkt_valid`=1 has three effects. It clears `txrdy` on the next cycle. It pulses `ep_irq` for exactly one cycle. In single mode it also clears `fifo_ne`.
- R7: In double mode, committing while the other slot is empty leaves `txrdy`=0, sets `fifo_ne`=1 and pulses `ep_irq` on the next cycle.
- R8: In double mode, with both slots committed, `txrdy`=1. After the first send, `txrdy`=0 and `fifo_ne`=1. After the second send, `fifo_ne`=0.
- R9: `usb_pkt_len` equals the committed byte count, zero included. The `usb_rdata` values appear in write order, advancing by one per `usb_rd` cycle.
- R10: Packets are presented to the USB side in commit order.
- R11: A write is dropped when no slot is free or when the current packet already holds `cfg_maxp` bytes. The drop sets `overrun`, which stays 1 until reset.
- R12: `flush` empties both slots and any partial load. It leaves `txrdy`=0, `fifo_ne`=0, `usb_pkt_valid`=0 and `ep_irq`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of all packets |
| cfg_maxp | input | LW | Maximum packet size in bytes |
| cfg_dbl | input | 1 | Request double buffering |
| cfg_auto | input | 1 | Commit automatically at maximum size |
| cpu_wr | input | 1 | Byte write strobe |
| cpu_wdata | input | DW | Byte written |
| cpu_set_rdy | input | 1 | Manual commit strobe |
| txrdy | output | 1 | Ready flag |
| fifo_ne | output | 1 | At least one packet queued |
| ep_irq | output | 1 | One-cycle endpoint interrupt |
| overrun | output | 1 | Sticky dropped-write flag |
| usb_pkt_valid | output | 1 | Head packet available |
| usb_pkt_len | output | LW | Byte count of the head packet |
| usb_rd | input | 1 | Advance to the next head-packet byte |
| usb_rdata | output | DW | Current byte of the head packet |
| usb_sent | input | 1 | Head packet sent successfully |

## Verification
The bench builds the block with DEPTH=16 and DW=8. Each half then holds only 8 bytes. A maximum size of 8 therefore sits exactly on the double-buffering threshold, and a size of 9 forces the single-packet fallback. Because packets are that short, the maximum-size overrun and the auto-commit edge both occur within a few writes. Mixing zero-length and short packets across both slots exercises length storage and ping-pong ordering.

// File: rtl/usb_in_pktbuf.sv
module usb_in_pktbuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [LW-1:0] cfg_maxp,
  input  logic          cfg_dbl,
  input  logic          cfg_auto,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_set_rdy,
  output logic          txrdy,
  output logic          fifo_ne,
  output logic          ep_irq,
  output logic          overrun,
  output logic          usb_pkt_valid,
  output logic [LW-1:0] usb_pkt_len,
  input  logic          usb_rd,
  output logic [DW-1:0] usb_rdata,
  input  logic          usb_sent
);
  localparam int HALF = DEPTH / 2;

  logic [DW-1:0] mem [DEPTH];
  logic [LW-1:0] plen [2];
  logic [1:0]    vld;
  logic          wsl, rsl, irq_q, ovr_q;
  logic [LW-1:0] wcnt, roff;

  logic          dbl_eff, can_load, wr_acc, auto_hit, commit, sent;
  logic [LW-1:0] cap, clen;
  logic [AW-1:0] waddr, raddr;

  assign dbl_eff  = cfg_dbl && (({1'b0, cfg_maxp} << 1) <= (LW+1)'(DEPTH));
  assign cap      = dbl_eff ? LW'(HALF) : LW'(DEPTH);
  assign can_load = dbl_eff ? !vld[wsl] : (vld == 2'b00);
  assign wr_acc   = cpu_wr && can_load && (wcnt < cfg_maxp) && (wcnt < cap);
  assign auto_hit = wr_acc && cfg_auto && (LW'(wcnt + 1'b1) == cfg_maxp);
  assign commit   = can_load && (cpu_set_rdy || auto_hit);
  assign clen     = wcnt + LW'(wr_acc);
  assign sent     = usb_sent && vld[rsl];
  assign waddr    = AW'(wcnt) + ((dbl_eff && wsl) ? AW'(HALF) : '0);
  assign raddr    = AW'(roff) + ((dbl_eff && rsl) ? AW'(HALF) : '0);

  always_ff @(posedge clk)
    if (wr_acc && !flush) mem[waddr] <= cpu_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0; wsl <= 1'b0; rsl <= 1'b0; wcnt <= '0; roff <= '0;
      irq_q <= 1'b0; ovr_q <= 1'b0;
      plen[0] <= '0; plen[1] <= '0;
    end else begin
      irq_q <= 1'b0;
      if (cpu_wr && !wr_acc) ovr_q <= 1'b1;
      if (flush) begin
        vld <= '0; wsl <= 1'b0; rsl <= 1'b0; wcnt <= '0; roff <= '0;
      end else begin
        if (wr_acc) wcnt <= wcnt + 1'b1;
        if (commit) begin
          vld[wsl]  <= 1'b1;
          plen[wsl] <= clen;
          wcnt      <= '0;
          if (dbl_eff) wsl <= ~wsl;
          if (dbl_eff && (!vld[~wsl] || sent)) irq_q <= 1'b1;
        end
        if (usb_rd && vld[rsl]) roff <= roff + 1'b1;
        if (sent) begin
          vld[rsl] <= 1'b0;
          roff     <= '0;
          if (dbl_eff) rsl <= ~rsl;
          irq_q    <= 1'b1;
        end
      end
    end
  end

  assign txrdy         = dbl_eff ? &vld : |vld;
  assign fifo_ne       = |vld;
  assign ep_irq        = irq_q;
  assign overrun       = ovr_q;
  assign usb_pkt_valid = vld[rsl];
  assign usb_pkt_len   = plen[rsl];
  assign usb_rdata     = mem[raddr];

  AST_SENT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    usb_sent && usb_pkt_valid && !flush |=> ep_irq && !txrdy); // R6
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !fifo_ne && !txrdy && !ep_irq && !usb_pkt_valid); // R12
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R11
  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl_eff && txrdy && !usb_sent && !flush |=> txrdy && fifo_ne); // R3
  AST_DBL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_eff && commit && !fifo_ne && !flush |=> !txrdy && fifo_ne && ep_irq); // R7
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    usb_pkt_valid |-> usb_pkt_len <= LW'(DEPTH)); // R9
  AST_AUTO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    auto_hit && !flush |=> fifo_ne); // R4
endmodule

// File: tb/usb_in_pktbuf_tb.sv
module usb_in_pktbuf_tb;
  localparam int TCLK  = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, flush = 0;
  logic [LW-1:0] cfg_maxp = 4;
  logic cfg_dbl = 0, cfg_auto = 0, cpu_wr = 0, cpu_set_rdy = 0;
  logic [DW-1:0] cpu_wdata = 0;
  logic txrdy, fifo_ne, ep_irq, overrun, usb_pkt_valid, usb_rd = 0, usb_sent = 0;
  logic [LW-1:0] usb_pkt_len;
  logic [DW-1:0] usb_rdata;

  int nvec = 0, nbad = 0;
  bit done = 0;
  logic [DW-1:0] exp_bytes [$];
  int exp_lens [$];
  logic [DW-1:0] seed = 8'h11;

  always #(TCLK/2) clk = ~clk;

  usb_in_pktbuf #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_maxp(cfg_maxp),
    .cfg_dbl(cfg_dbl), .cfg_auto(cfg_auto), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_set_rdy(cpu_set_rdy), .txrdy(txrdy),
    .fifo_ne(fifo_ne), .ep_irq(ep_irq), .overrun(overrun),
    .usb_pkt_valid(usb_pkt_valid), .usb_pkt_len(usb_pkt_len),
    .usb_rd(usb_rd), .usb_rdata(usb_rdata), .usb_sent(usb_sent));

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: writes n bytes, pushes the first `keep` into the scoreboard.
  task automatic load(int n, int keep, bit strobe);
    for (int i = 0; i < n; i++) begin
      cpu_wr = 1; cpu_wdata = seed;
      if (i < keep) exp_bytes.push_back(seed);
      seed = seed + 8'd23;
      @(negedge clk);
      cpu_wr = 0;
    end
    if (strobe) begin
      cpu_set_rdy = 1; @(negedge clk); cpu_set_rdy = 0;
    end
  endtask

  // Monitor: pops the scoreboard while the USB side drains a packet.
  task automatic send(string req);
    int l;
    chk({req, " valid"}, int'(usb_pkt_valid), 1);
    l = exp_lens.pop_front();
    chk({req, " R9 len"}, int'(usb_pkt_len), l);
    for (int i = 0; i < l; i++) begin
      chk({req, " R10 data"}, int'(usb_rdata), int'(exp_bytes.pop_front()));
      usb_rd = 1; @(negedge clk); usb_rd = 0;
    end
    usb_sent = 1; @(negedge clk); usb_sent = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 txrdy", int'(txrdy), 0);
    chk("R1 fifo_ne", int'(fifo_ne), 0);
    chk("R1 ep_irq", int'(ep_irq), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 valid", int'(usb_pkt_valid), 0);

    // single mode, manual short packet
    load(3, 3, 1); exp_lens.push_back(3);
    chk("R3 txrdy", int'(txrdy), 1);
    chk("R3 fifo_ne", int'(fifo_ne), 1);
    chk("R3 no irq", int'(ep_irq), 0);
    load(1, 0, 0);
    chk("R11 overrun when full", int'(overrun), 1);
    chk("R3 txrdy held", int'(txrdy), 1);
    send("R3");
    chk("R6 txrdy", int'(txrdy), 0);
    chk("R6 fifo_ne", int'(fifo_ne), 0);
    chk("R6 irq", int'(ep_irq), 1);
    @(negedge clk);
    chk("R6 irq one cycle", int'(ep_irq), 0);

    // auto commit at max size
    cfg_auto = 1;
    load(4, 4, 0); exp_lens.push_back(4);
    chk("R4 txrdy", int'(txrdy), 1);
    send("R4");
    // short packet with auto needs strobe
    load(2, 2, 0);
    chk("R5 txrdy short", int'(txrdy), 0);
    chk("R5 fifo_ne short", int'(fifo_ne), 0);
    cpu_set_rdy = 1; @(negedge clk); cpu_set_rdy = 0; exp_lens.push_back(2);
    chk("R5 txrdy after strobe", int'(txrdy), 1);
    send("R5");
    cfg_auto = 0;

    // double mode, maxp 8 on threshold
    cfg_dbl = 1; cfg_maxp = 8;
    load(5, 5, 1); exp_lens.push_back(5);
    chk("R7 txrdy", int'(txrdy), 0);
    chk("R7 fifo_ne", int'(fifo_ne), 1);
    chk("R7 irq", int'(ep_irq), 1);
    load(0, 0, 1); exp_lens.push_back(0);
    chk("R8 txrdy both", int'(txrdy), 1);
    send("R8 first");
    chk("R8 txrdy after one", int'(txrdy), 0);
    chk("R8 fifo_ne after one", int'(fifo_ne), 1);
    chk("R8 irq", int'(ep_irq), 1);
    load(8, 8, 0); cpu_set_rdy = 1; @(negedge clk); cpu_set_rdy = 0;
    exp_lens.push_back(8);
    chk("R8 txrdy refill", int'(txrdy), 1);
    send("R10 zero-length");
    send("R10 third");
    chk("R8 fifo_ne drained", int'(fifo_ne), 0);

    // fallback to single when 2*maxp > DEPTH
    cfg_maxp = 9;
    load(3, 3, 1); exp_lens.push_back(3);
    chk("R2 txrdy single fallback", int'(txrdy), 1);
    chk("R2 no irq", int'(ep_irq), 0);
    send("R2");

    // overrun past maxp, after fresh reset
    cfg_dbl = 0; cfg_maxp = 2;
    do_reset();
    chk("R11 cleared by reset", int'(overrun), 0);
    load(3, 2, 1); exp_lens.push_back(2);
    chk("R11 overrun past maxp", int'(overrun), 1);
    send("R11");
    @(negedge clk);
    chk("R11 sticky", int'(overrun), 1);

    // flush
    cfg_dbl = 1; cfg_maxp = 8;
    load(4, 0, 1);
    load(2, 0, 0);
    @(negedge clk);
    flush = 1; @(negedge clk); flush = 0;
    chk("R12 txrdy", int'(txrdy), 0);
    chk("R12 fifo_ne", int'(fifo_ne), 0);
    chk("R12 valid", int'(usb_pkt_valid), 0);
    chk("R12 irq", int'(ep_irq), 0);
    load(3, 3, 1); exp_lens.push_back(3);
    send("R12 after flush");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule